// File: doc/BRIEF.md
# Move Operand Address Generator

This block serves the two-operand memory move of a small 18-bit processor with sixteen registers. It takes the instruction word and the two register-file values named by that word. From them it works out where the source operand is read and where the destination operand is written. Each side is handled under its own addressing mode: direct register, base plus a short unsigned displacement, pre-decrement, or post-increment. Because the two sides are independent, one instruction can copy a word from memory to memory and step both pointers at once.

A move occupies two cycles. In the issue cycle the block decodes the word and presents the memory read request for an indirect source. It also raises busy so the core holds its fetch for that cycle. In the following cycle it presents the destination write request, or a register load for a direct destination, together with any pointer updates for the register file. A move that names a register on both sides is rejected: it raises an illegal flag and causes no memory access and no register write. Words that are not moves pass through without effect.

Top module: `mvaddr_gen`

## Requirements
- R1: Only a word with bits 17:16 equal to 01 presented with issue_i high is acted on. Any other word causes no read, write, load, writeback, busy or illegal output.
- R2: A move whose source mode (bits 15:14) and destination mode (bits 13:12) are both 00 raises illegal_o in its issue cycle. It raises neither rd_en_o nor busy_o then, and in the next cycle it produces no write, load or writeback.
- R3: busy_o is high in the issue cycle of every legal move and in no other cycle. A new move may issue in the cycle after another.
- R4: Mode 01 addresses base plus the zero-extended displacement in bits 3:0 and does not write the base back.
- R5: Mode 10 addresses base-1 and writes base-1 back to that base register in the cycle after issue.
- R6: Mode 11 addresses base and writes base+1 back to that base register in the cycle after issue.
- R7: For a source mode other than 00, rd_en_o and rd_addr_o appear in the issue cycle, computed from src_base_i. Source mode 00 makes no memory read.
- R8: For a destination mode other than 00, wr_en_o and wr_addr_o appear in the cycle after issue, computed from dst_base_i as sampled at issue. Destination mode 00 instead raises ld_en_o in that cycle, with ld_idx_o equal to the destination index.
- R9: Source and destination writebacks appear in the same cycle. When both name the same register, only the destination writeback is given.
- R10: Synchronous reset clears every next-cycle output, including work captured in the cycle reset is applied.
- R11: All address and writeback arithmetic wraps modulo 2^DW.
- R12: src_sel_o always equals bits 7:4 and dst_sel_o always equals bits 11:8 of instr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 18 | Instruction word |
| src_base_i | input | DW | Register-file value of the source index |
| dst_base_i | input | DW | Register-file value of the destination index |
| src_sel_o | output | 4 | Source register index for the register-file read |
| dst_sel_o | output | 4 | Destination register index for the register-file read |
| busy_o | output | 1 | First cycle of a legal move |
| illegal_o | output | 1 | Register-to-register move rejected |
| rd_en_o | output | 1 | Memory read request (issue cycle) |
| rd_addr_o | output | DW | Memory read address |
| wr_en_o | output | 1 | Memory write request (second cycle) |
| wr_addr_o | output | DW | Memory write address |
| ld_en_o | output | 1 | Load read data into a register (second cycle) |
| ld_idx_o | output | 4 | Register receiving the load |
| wb_src_en_o | output | 1 | Source pointer writeback |
| wb_src_idx_o | output | 4 | Source pointer register |
| wb_src_val_o | output | DW | Source pointer new value |
| wb_dst_en_o | output | 1 | Destination pointer writeback |
| wb_dst_idx_o | output | 4 | Destination pointer register |
| wb_dst_val_o | output | DW | Destination pointer new value |

## Verification
The bench drives each mode on each side and checks the pre-decrement and post-increment pair. A design that swapped them would address the wrong word or step the pointer the wrong way. It also checks pointer arithmetic at 0 and at the top of the address range, where a narrow adder would fail to wrap. A copy where both pointers are the same register must leave one writeback, so a design that issued both would show conflicting register updates. The bench sends the rejected register-to-register form, back-to-back moves, and a reset that lands on a captured move, to catch stray writes, a dropped busy and stale second-cycle outputs.

// File: rtl/mvaddr_pkg.sv
package mvaddr_pkg;

    localparam int INSTR_W = 18;
    localparam int RIDX_W  = 4;
    localparam int DISP_W  = 4;

    typedef enum logic [1:0] {
        AM_REG  = 2'b00,
        AM_DISP = 2'b01,
        AM_PRE  = 2'b10,
        AM_POST = 2'b11
    } amode_e;

    typedef struct packed {
        logic              is_move;
        amode_e            smode;
        amode_e            dmode;
        logic [RIDX_W-1:0] dreg;
        logic [RIDX_W-1:0] sreg;
        logic [DISP_W-1:0] disp;
    } mv_fields_t;

    function automatic mv_fields_t split_word(input logic [INSTR_W-1:0] w);
        mv_fields_t f;
        f.is_move = (w[17:16] == 2'b01);
        f.smode   = amode_e'(w[15:14]);
        f.dmode   = amode_e'(w[13:12]);
        f.dreg    = w[11:8];
        f.sreg    = w[7:4];
        f.disp    = w[3:0];
        return f;
    endfunction

    function automatic logic via_memory(input amode_e m);
        return (m != AM_REG);
    endfunction

endpackage

// File: rtl/mvaddr_decode.sv
module mvaddr_decode
    import mvaddr_pkg::*;
(
    input  logic               issue,
    input  logic [INSTR_W-1:0] word,
    output mv_fields_t         fields,
    output logic               go,
    output logic               reject
);
    logic both_direct;

    always_comb begin
        fields      = split_word(word);
        both_direct = !via_memory(fields.smode) && !via_memory(fields.dmode);
        go          = issue && fields.is_move && !both_direct;
        reject      = issue && fields.is_move && both_direct;
    end
endmodule

// File: rtl/mvaddr_calc.sv
module mvaddr_calc
    import mvaddr_pkg::*;
#(
    parameter int DW = 18
) (
    input  amode_e            mode,
    input  logic [DW-1:0]     base,
    input  logic [DISP_W-1:0] disp,
    output logic [DW-1:0]     addr,
    output logic              wb_en,
    output logic [DW-1:0]     wb_val
);
    localparam logic [DW-1:0] ONE = DW'(1);
    logic [DW-1:0] disp_ext;

    always_comb begin
        disp_ext = DW'(disp);
        addr     = base;
        wb_en    = 1'b0;
        wb_val   = base;
        case (mode)
            AM_DISP: addr = base + disp_ext;
            AM_PRE: begin
                addr   = base - ONE;
                wb_en  = 1'b1;
                wb_val = base - ONE;
            end
            AM_POST: begin
                addr   = base;
                wb_en  = 1'b1;
                wb_val = base + ONE;
            end
            default: addr = base;
        endcase
    end
endmodule

// File: rtl/mvaddr_stage.sv
module mvaddr_stage
    import mvaddr_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  mv_fields_t        fields,
    input  logic [DW-1:0]     dst_addr,
    input  logic              s_wb_en,
    input  logic [DW-1:0]     s_wb_val,
    input  logic              d_wb_en,
    input  logic [DW-1:0]     d_wb_val,
    output logic              wr_en,
    output logic [DW-1:0]     wr_addr,
    output logic              ld_en,
    output logic [RIDX_W-1:0] ld_idx,
    output logic              ws_en,
    output logic [RIDX_W-1:0] ws_idx,
    output logic [DW-1:0]     ws_val,
    output logic              wd_en,
    output logic [RIDX_W-1:0] wd_idx,
    output logic [DW-1:0]     wd_val
);
    logic same_reg;
    assign same_reg = (fields.sreg == fields.dreg);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            ld_en   <= 1'b0;
            ld_idx  <= '0;
            ws_en   <= 1'b0;
            ws_idx  <= '0;
            ws_val  <= '0;
            wd_en   <= 1'b0;
            wd_idx  <= '0;
            wd_val  <= '0;
        end else begin
            wr_en  <= go && via_memory(fields.dmode);
            ld_en  <= go && !via_memory(fields.dmode);
            ws_en  <= go && s_wb_en && !(d_wb_en && same_reg);
            wd_en  <= go && d_wb_en;
            if (go) begin
                wr_addr <= dst_addr;
                ld_idx  <= fields.dreg;
                ws_idx  <= fields.sreg;
                ws_val  <= s_wb_val;
                wd_idx  <= fields.dreg;
                wd_val  <= d_wb_val;
            end
        end
    end
endmodule

// File: rtl/mvaddr_gen.sv
module mvaddr_gen
    import mvaddr_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DW-1:0]      src_base_i,
    input  logic [DW-1:0]      dst_base_i,
    output logic [RIDX_W-1:0]  src_sel_o,
    output logic [RIDX_W-1:0]  dst_sel_o,
    output logic               busy_o,
    output logic               illegal_o,
    output logic               rd_en_o,
    output logic [DW-1:0]      rd_addr_o,
    output logic               wr_en_o,
    output logic [DW-1:0]      wr_addr_o,
    output logic               ld_en_o,
    output logic [RIDX_W-1:0]  ld_idx_o,
    output logic               wb_src_en_o,
    output logic [RIDX_W-1:0]  wb_src_idx_o,
    output logic [DW-1:0]      wb_src_val_o,
    output logic               wb_dst_en_o,
    output logic [RIDX_W-1:0]  wb_dst_idx_o,
    output logic [DW-1:0]      wb_dst_val_o
);
    localparam int OPS = 2;   // 0 = source side, 1 = destination side

    mv_fields_t    fields;
    logic          go;
    amode_e        op_mode [OPS];
    logic [DW-1:0] op_base [OPS];
    logic [DW-1:0] op_addr [OPS];
    logic          op_wben [OPS];
    logic [DW-1:0] op_wbv  [OPS];

    mvaddr_decode u_dec (
        .issue  (issue_i),
        .word   (instr_i),
        .fields (fields),
        .go     (go),
        .reject (illegal_o)
    );

    assign op_mode[0] = fields.smode;
    assign op_mode[1] = fields.dmode;
    assign op_base[0] = src_base_i;
    assign op_base[1] = dst_base_i;

    for (genvar g = 0; g < OPS; g++) begin : g_side
        mvaddr_calc #(.DW(DW)) u_calc (
            .mode   (op_mode[g]),
            .base   (op_base[g]),
            .disp   (fields.disp),
            .addr   (op_addr[g]),
            .wb_en  (op_wben[g]),
            .wb_val (op_wbv[g])
        );
    end

    assign src_sel_o = fields.sreg;
    assign dst_sel_o = fields.dreg;
    assign busy_o    = go;
    assign rd_en_o   = go && via_memory(fields.smode);
    assign rd_addr_o = op_addr[0];

    mvaddr_stage #(.DW(DW)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .fields   (fields),
        .dst_addr (op_addr[1]),
        .s_wb_en  (op_wben[0]),
        .s_wb_val (op_wbv[0]),
        .d_wb_en  (op_wben[1]),
        .d_wb_val (op_wbv[1]),
        .wr_en    (wr_en_o),
        .wr_addr  (wr_addr_o),
        .ld_en    (ld_en_o),
        .ld_idx   (ld_idx_o),
        .ws_en    (wb_src_en_o),
        .ws_idx   (wb_src_idx_o),
        .ws_val   (wb_src_val_o),
        .wd_en    (wb_dst_en_o),
        .wd_idx   (wb_dst_idx_o),
        .wd_val   (wb_dst_val_o)
    );
endmodule

// File: rtl/mvaddr_chk.sv
module mvaddr_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          issue_i,
    input logic [17:0]   instr_i,
    input logic [DW-1:0] src_base_i,
    input logic          busy_o,
    input logic          illegal_o,
    input logic          rd_en_o,
    input logic [DW-1:0] rd_addr_o,
    input logic          wr_en_o,
    input logic          ld_en_o,
    input logic          wb_src_en_o,
    input logic [3:0]    wb_src_idx_o,
    input logic          wb_dst_en_o,
    input logic [3:0]    wb_dst_idx_o
);
    // R2
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!rd_en_o && !busy_o));

    // R2
    illegal_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> (!wr_en_o && !ld_en_o && !wb_src_en_o && !wb_dst_en_o));

    // R3
    busy_needs_issue_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (issue_i && instr_i[17:16] == 2'b01));

    // R8
    second_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (wr_en_o != ld_en_o));

    // R8
    no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> (!wr_en_o && !ld_en_o && !wb_src_en_o && !wb_dst_en_o));

    // R7
    read_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |-> busy_o);

    // R6
    postinc_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en_o && instr_i[15:14] == 2'b11) |-> (rd_addr_o == src_base_i));

    // R9
    one_wb_per_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_src_en_o && wb_dst_en_o) |-> (wb_src_idx_o != wb_dst_idx_o));
endmodule

bind mvaddr_gen mvaddr_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .issue_i      (issue_i),
    .instr_i      (instr_i),
    .src_base_i   (src_base_i),
    .busy_o       (busy_o),
    .illegal_o    (illegal_o),
    .rd_en_o      (rd_en_o),
    .rd_addr_o    (rd_addr_o),
    .wr_en_o      (wr_en_o),
    .ld_en_o      (ld_en_o),
    .wb_src_en_o  (wb_src_en_o),
    .wb_src_idx_o (wb_src_idx_o),
    .wb_dst_en_o  (wb_dst_en_o),
    .wb_dst_idx_o (wb_dst_idx_o)
);

// File: tb/sim_mvaddr_gen.sv
module sim_mvaddr_gen;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          issue_i = 1'b0;
    logic [17:0]   instr_i = '0;
    logic [DW-1:0] src_base_i = '0;
    logic [DW-1:0] dst_base_i = '0;
    logic [3:0]    src_sel_o, dst_sel_o, ld_idx_o, wb_src_idx_o, wb_dst_idx_o;
    logic          busy_o, illegal_o, rd_en_o, wr_en_o, ld_en_o, wb_src_en_o, wb_dst_en_o;
    logic [DW-1:0] rd_addr_o, wr_addr_o, wb_src_val_o, wb_dst_val_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mvaddr_gen #(.DW(DW)) u0 (
        .clk(clk), .rst(rst), .issue_i(issue_i), .instr_i(instr_i),
        .src_base_i(src_base_i), .dst_base_i(dst_base_i),
        .src_sel_o(src_sel_o), .dst_sel_o(dst_sel_o),
        .busy_o(busy_o), .illegal_o(illegal_o),
        .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .ld_en_o(ld_en_o), .ld_idx_o(ld_idx_o),
        .wb_src_en_o(wb_src_en_o), .wb_src_idx_o(wb_src_idx_o), .wb_src_val_o(wb_src_val_o),
        .wb_dst_en_o(wb_dst_en_o), .wb_dst_idx_o(wb_dst_idx_o), .wb_dst_val_o(wb_dst_val_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] mv(input logic [1:0] sm, input logic [1:0] dm,
                                       input logic [3:0] d, input logic [3:0] s,
                                       input logic [3:0] off);
        return {2'b01, sm, dm, d, s, off};
    endfunction

    // Present a word at a falling edge; outputs of the issue cycle are then visible.
    task automatic present(input logic [17:0] w, input logic [DW-1:0] sb, input logic [DW-1:0] db);
        @(negedge clk);
        issue_i = 1'b1; instr_i = w; src_base_i = sb; dst_base_i = db;
        #1;
    endtask

    // Move to the next falling edge with no issue; second-cycle outputs are then visible.
    task automatic idle_next();
        @(negedge clk);
        issue_i = 1'b0; instr_i = '0; src_base_i = '0; dst_base_i = '0;
        #1;
    endtask

    task automatic t_reset();
        check("R10 wr_en after reset", wr_en_o, 0);
        check("R10 ld_en after reset", ld_en_o, 0);
        check("R10 wb after reset", {wb_src_en_o, wb_dst_en_o}, 0);
        present(mv(2'b11, 2'b11, 4'd1, 4'd2, 4'd0), 18'd10, 18'd20);
        rst = 1'b1;
        idle_next();
        rst = 1'b0;
        check("R10 captured move cleared", {wr_en_o, wb_src_en_o, wb_dst_en_o, ld_en_o}, 0);
    endtask

    task automatic t_sel();
        present({2'b10, 4'h0, 4'hA, 4'h5, 4'h0}, 18'd0, 18'd0);
        check("R12 src_sel", src_sel_o, 32'h5);
        check("R12 dst_sel", dst_sel_o, 32'hA);
        idle_next();
    endtask

    task automatic t_nonmove();
        present({2'b00, 4'b0101, 4'h3, 4'h4, 4'h2}, 18'd100, 18'd200);
        check("R1 non-move no busy/read/illegal", {busy_o, rd_en_o, illegal_o}, 0);
        idle_next();
        check("R1 non-move no second cycle", {wr_en_o, ld_en_o, wb_src_en_o, wb_dst_en_o}, 0);
        // a move word without issue is ignored too
        @(negedge clk);
        issue_i = 1'b0; instr_i = mv(2'b11, 2'b11, 4'd1, 4'd2, 4'd0); src_base_i = 18'd5; dst_base_i = 18'd6;
        #1;
        check("R1 no issue no busy", {busy_o, rd_en_o}, 0);
        idle_next();
        check("R1 no issue no write", {wr_en_o, wb_src_en_o, wb_dst_en_o}, 0);
    endtask

    task automatic t_disp();
        present(mv(2'b01, 2'b01, 4'd3, 4'd4, 4'd5), 18'd100, 18'd200);
        check("R4 rd_en", rd_en_o, 1);
        check("R4 rd_addr base+disp", rd_addr_o, 32'd105);
        check("R3 busy in issue", busy_o, 1);
        idle_next();
        check("R3 busy drops", busy_o, 0);
        check("R4 wr_en", wr_en_o, 1);
        check("R4 wr_addr base+disp", wr_addr_o, 32'd205);
        check("R4 no writeback", {wb_src_en_o, wb_dst_en_o}, 0);
    endtask

    task automatic t_predec();
        present(mv(2'b10, 2'b10, 4'd7, 4'd6, 4'd9), 18'd50, 18'd7);
        check("R5 rd_addr base-1", rd_addr_o, 32'd49);
        idle_next();
        check("R5 wr_addr base-1", wr_addr_o, 32'd6);
        check("R5 src wb en", wb_src_en_o, 1);
        check("R5 src wb idx", wb_src_idx_o, 32'd6);
        check("R5 src wb val", wb_src_val_o, 32'd49);
        check("R5 dst wb idx/val", {wb_dst_en_o, wb_dst_idx_o, wb_dst_val_o}, {1'b1, 4'd7, 18'd6});
    endtask

    task automatic t_postinc();
        present(mv(2'b11, 2'b11, 4'd2, 4'd9, 4'd3), 18'd300, 18'd400);
        check("R6 rd_addr base", rd_addr_o, 32'd300);
        idle_next();
        check("R6 wr_addr base", wr_addr_o, 32'd400);
        check("R6 src wb", {wb_src_en_o, wb_src_idx_o, wb_src_val_o}, {1'b1, 4'd9, 18'd301});
        check("R6 dst wb", {wb_dst_en_o, wb_dst_idx_o, wb_dst_val_o}, {1'b1, 4'd2, 18'd401});
    endtask

    task automatic t_direct_src();
        present(mv(2'b00, 2'b11, 4'd8, 4'd1, 4'd0), 18'd77, 18'd1000);
        check("R7 direct src no read", rd_en_o, 0);
        check("R7 direct src busy", busy_o, 1);
        idle_next();
        check("R8 wr after direct src", {wr_en_o, wr_addr_o}, {1'b1, 18'd1000});
        check("R8 no load", ld_en_o, 0);
        check("R7 no src wb", wb_src_en_o, 0);
    endtask

    task automatic t_direct_dst();
        present(mv(2'b11, 2'b00, 4'd12, 4'd3, 4'd0), 18'd40, 18'd0);
        check("R7 read in issue", {rd_en_o, rd_addr_o}, {1'b1, 18'd40});
        idle_next();
        check("R8 direct dst no write", wr_en_o, 0);
        check("R8 load", {ld_en_o, ld_idx_o}, {1'b1, 4'd12});
        check("R8 src wb on direct dst", {wb_src_en_o, wb_src_val_o}, {1'b1, 18'd41});
    endtask

    task automatic t_illegal();
        present(mv(2'b00, 2'b00, 4'd1, 4'd2, 4'd3), 18'd5, 18'd6);
        check("R2 illegal flag", illegal_o, 1);
        check("R2 no busy/read", {busy_o, rd_en_o}, 0);
        idle_next();
        check("R2 illegal clears", illegal_o, 0);
        check("R2 no second cycle", {wr_en_o, ld_en_o, wb_src_en_o, wb_dst_en_o}, 0);
    endtask

    task automatic t_collision();
        present(mv(2'b11, 2'b10, 4'd4, 4'd4, 4'd0), 18'd90, 18'd90);
        idle_next();
        check("R9 src wb dropped", wb_src_en_o, 0);
        check("R9 dst wb kept", {wb_dst_en_o, wb_dst_idx_o, wb_dst_val_o}, {1'b1, 4'd4, 18'd89});
        present(mv(2'b11, 2'b11, 4'd5, 4'd6, 4'd0), 18'd10, 18'd20);
        idle_next();
        check("R9 both wb same cycle", {wb_src_en_o, wb_dst_en_o}, 2'b11);
    endtask

    task automatic t_wrap();
        present(mv(2'b10, 2'b11, 4'd1, 4'd2, 4'd0), 18'd0, 18'h3FFFF);
        check("R11 pre-dec from 0", rd_addr_o, 32'h3FFFF);
        idle_next();
        check("R11 src wb wraps", wb_src_val_o, 32'h3FFFF);
        check("R11 post-inc wraps", wb_dst_val_o, 32'd0);
        present(mv(2'b01, 2'b01, 4'd1, 4'd2, 4'd3), 18'h3FFFE, 18'h3FFFF);
        check("R11 disp wraps src", rd_addr_o, 32'd1);
        idle_next();
        check("R11 disp wraps dst", wr_addr_o, 32'd2);
    endtask

    task automatic t_back_to_back();
        present(mv(2'b11, 2'b11, 4'd1, 4'd2, 4'd0), 18'd10, 18'd20);
        @(negedge clk);
        instr_i = mv(2'b10, 2'b01, 4'd3, 4'd5, 4'd2); src_base_i = 18'd70; dst_base_i = 18'd80;
        #1;
        check("R3 busy on second issue", busy_o, 1);
        check("R3 second read", rd_addr_o, 32'd69);
        check("R3 first write", wr_addr_o, 32'd20);
        idle_next();
        check("R3 second write", wr_addr_o, 32'd82);
        check("R3 second src wb", {wb_src_en_o, wb_src_idx_o, wb_src_val_o}, {1'b1, 4'd5, 18'd69});
        check("R3 busy low after", busy_o, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst = 1'b0;
                #1;
                t_reset();
                t_sel();
                t_nonmove();
                t_disp();
                t_predec();
                t_postinc();
                t_direct_src();
                t_direct_dst();
                t_illegal();
                t_collision();
                t_wrap();
                t_back_to_back();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule